// File: doc/BRIEF.md
# Quadrature Shift-Add Oscillator

This block produces a sine word and a cosine word on every clock edge from two integrators that feed each other. The sine integrator adds a scaled copy of the cosine register, and the cosine integrator subtracts a scaled copy of the sine register. Each scale factor is an arithmetic right shift by `SHIFT` bit positions, so the loop has no multiplier and no table. The output frequency is set by `SHIFT` and is roughly one cycle every 2*pi*2^SHIFT clocks.

The loop contains no noise source to start it, so the zero state stays at zero. A synchronous `load` pulse seeds the cosine register with the requested amplitude and clears the sine register. Both updates read the register values from before the clock edge. The loop gain is therefore slightly above one, and the amplitude grows slowly. When a sum would leave the register range, it is clamped at full scale and a sticky flag records the event. Each output word is the upper `OUT_W` bits of its register, so the bits below the output field act as guard bits for the shifted terms.

Top module: `quad_osc`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), both internal registers and `ovf_flag` are zero, so `sin_out`, `cos_out` and `ovf_flag` read 0.
- R2: After reset, if `load` has not been pulsed, the outputs stay at 0 on every clock. The zero state does not start oscillating by itself.
- R3: A clock edge with `load` high sets the sine register to 0, sets the cosine register to `amp_init`, and clears `ovf_flag`.
- R4: On every clock edge without `load`, the sine register becomes sat(s + floor(c / 2^SHIFT)), where c is the cosine register value from before the edge. This produces a new sample on every clock.
- R5: On the same edge, the cosine register becomes sat(c - floor(s / 2^SHIFT)), where s is the sine value from before the edge, not the newly updated sine value.
- R6: `sin_out` and `cos_out` are bits [ACC_W-1 : ACC_W-OUT_W] of their registers, which equals floor(register / 2^(ACC_W-OUT_W)) in two's complement (bits 23..8 with the defaults).
- R7: A sum above 2^(ACC_W-1)-1 is clamped to that value, and a sum below -2^(ACC_W-1) is clamped to that value. A sum never wraps around.
- R8: `ovf_flag` goes high on the edge after any clamp in a non-load cycle. It stays high until a reset or a `load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Synchronous preload of the amplitude |
| amp_init | input | ACC_W | Signed starting value for the cosine register |
| sin_out | output | OUT_W | Signed sine word |
| cos_out | output | OUT_W | Signed cosine word |
| ovf_flag | output | 1 | Sticky saturation indicator |

## Verification
The scoreboard keeps a full-width model of both registers and compares the truncated words every cycle. If the cosine update used the new sine value, the bench would see the orbit drift within a few cycles, because the model follows the slowly growing forward-Euler loop. A full-scale preload makes the amplitude reach the register limits, so a design that wraps would show a sign flip where the model holds at the maximum, and a missing flag would show as a mismatch on `ovf_flag`. Negative preloads with nonzero low bits test the floor behaviour of both the arithmetic shift and the truncation, which a logical shift or a rounding design would get wrong. A run with no preload after reset confirms that the zero state stays at zero.

// File: rtl/osc_pkg.sv
package osc_pkg;
  // Direction of the step an integrator takes with its shifted feed term.
  typedef enum logic {
    STEP_ADD = 1'b0,
    STEP_SUB = 1'b1
  } step_dir_e;
endpackage

// File: rtl/osc_integrator.sv
module osc_integrator
  import osc_pkg::*;
#(
  parameter int        ACC_W = 24,
  parameter int        SHIFT = 6,
  parameter step_dir_e DIR   = STEP_ADD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] load_val,
  input  logic signed [ACC_W-1:0] feed,
  output logic signed [ACC_W-1:0] q,
  output logic                    sat_evt
);
  localparam int EXT_W = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] TOP_V = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] BOT_V = {1'b1, {(ACC_W-1){1'b0}}};

  // Power-of-two scaling: arithmetic shift, pure bit selection.
  function automatic logic signed [ACC_W-1:0] scale_down(input logic signed [ACC_W-1:0] v);
    return v >>> SHIFT;
  endfunction

  // One extra bit of headroom so the clamp can see the true sum.
  function automatic logic signed [EXT_W-1:0] raw_step(input logic signed [ACC_W-1:0] cur,
                                                      input logic signed [ACC_W-1:0] term);
    logic signed [EXT_W-1:0] a;
    logic signed [EXT_W-1:0] b;
    a = {cur[ACC_W-1], cur};
    b = {term[ACC_W-1], term};
    return (DIR == STEP_ADD) ? (a + b) : (a - b);
  endfunction

  function automatic logic out_of_range(input logic signed [EXT_W-1:0] w);
    return w[EXT_W-1] != w[EXT_W-2];
  endfunction

  function automatic logic signed [ACC_W-1:0] clamp(input logic signed [EXT_W-1:0] w);
    if (!out_of_range(w)) return w[ACC_W-1:0];
    return w[EXT_W-1] ? BOT_V : TOP_V;
  endfunction

  logic signed [ACC_W-1:0] q_r;
  logic signed [ACC_W-1:0] term;
  logic signed [EXT_W-1:0] wide;
  logic signed [ACC_W-1:0] nxt;

  always_comb begin
    term    = scale_down(feed);
    wide    = raw_step(q_r, term);
    sat_evt = out_of_range(wide);
    nxt     = clamp(wide);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (load) q_r <= load_val;
    else           q_r <= nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/osc_slice.sv
module osc_slice #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 16
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [OUT_W-1:0] word
);
  localparam int DROP = ACC_W - OUT_W;

  // Keeping the upper field is a floor division by 2^DROP.
  function automatic logic signed [OUT_W-1:0] upper_field(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] sh;
    sh = v >>> DROP;
    return sh[OUT_W-1:0];
  endfunction

  assign word = upper_field(acc);
endmodule

// File: rtl/quad_osc.sv
module quad_osc
  import osc_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int OUT_W = 16,
  parameter int SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] amp_init,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out,
  output logic                    ovf_flag
);
  localparam int GUARD = ACC_W - OUT_W;
  localparam logic signed [ACC_W-1:0] ZERO_V = '0;

  // Named internal events for the checker.
  logic signed [ACC_W-1:0] s_q;
  logic signed [ACC_W-1:0] c_q;
  logic                    sat_s;
  logic                    sat_c;
  logic                    ovf_q;
  logic                    clamp_seen;

  // Sine: adds the shifted cosine.
  osc_integrator #(.ACC_W(ACC_W), .SHIFT(SHIFT), .DIR(STEP_ADD)) i_sin_int (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(ZERO_V),
    .feed(c_q), .q(s_q), .sat_evt(sat_s)
  );

  // Cosine: subtracts the shifted sine from before the edge.
  osc_integrator #(.ACC_W(ACC_W), .SHIFT(SHIFT), .DIR(STEP_SUB)) i_cos_int (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(amp_init),
    .feed(s_q), .q(c_q), .sat_evt(sat_c)
  );

  generate
    if (GUARD > 0) begin : g_trunc
      osc_slice #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_sin_slice (.acc(s_q), .word(sin_out));
      osc_slice #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_cos_slice (.acc(c_q), .word(cos_out));
    end else begin : g_full
      assign sin_out = s_q[OUT_W-1:0];
      assign cos_out = c_q[OUT_W-1:0];
    end
  endgenerate

  assign clamp_seen = (sat_s | sat_c) & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_q <= 1'b0;
    else if (load)       ovf_q <= 1'b0;
    else if (clamp_seen) ovf_q <= 1'b1;
  end

  assign ovf_flag = ovf_q;
endmodule

// File: rtl/quad_osc_chk.sv
module quad_osc_chk #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 16,
  parameter int SHIFT = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load,
  input logic signed [ACC_W-1:0] amp_init,
  input logic signed [OUT_W-1:0] sin_out,
  input logic signed [OUT_W-1:0] cos_out,
  input logic                    ovf_flag,
  input logic signed [ACC_W-1:0] s_q,
  input logic signed [ACC_W-1:0] c_q,
  input logic                    sat_s,
  input logic                    sat_c
);
  localparam logic signed [ACC_W-1:0] TOP_V = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] BOT_V = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] STEP1 = ACC_W'(1) <<< SHIFT;
  localparam logic signed [ACC_W-1:0] ZV    = '0;

  // R1
  always @(posedge clk) begin
    if (rst_n === 1'b0)
      reset_state_chk: assert (sin_out == '0 && cos_out == '0 && ovf_flag == 1'b0);
  end

  // R2
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_q == ZV && c_q == ZV && !load) |=> (s_q == ZV && c_q == ZV));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (s_q == ZV && c_q == $past(amp_init) && !ovf_flag));

  // R4
  sin_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !sat_s && c_q >= STEP1) |=> (s_q > $past(s_q)));

  // R5
  cos_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !sat_c && s_q >= STEP1) |=> (c_q < $past(c_q)));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (sat_s || sat_c)) |=> (s_q == TOP_V || s_q == BOT_V || c_q == TOP_V || c_q == BOT_V));

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (sat_s || sat_c)) |=> ovf_flag);

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !load) |=> ovf_flag);
endmodule

bind quad_osc quad_osc_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) i_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .amp_init(amp_init),
  .sin_out(sin_out), .cos_out(cos_out), .ovf_flag(ovf_flag),
  .s_q(s_q), .c_q(c_q), .sat_s(sat_s), .sat_c(sat_c)
);

// File: tb/test_quad_osc.sv
module test_quad_osc;
  localparam int ACC_W = 24;
  localparam int OUT_W = 16;
  localparam int SHIFT = 6;
  localparam longint TOPV = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint BOTV = -(64'sd1 <<< (ACC_W-1));
  localparam longint FSTEP = 64'sd1 <<< SHIFT;
  localparam longint FOUT  = 64'sd1 <<< (ACC_W-OUT_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic signed [ACC_W-1:0] amp_init = '0;
  logic signed [OUT_W-1:0] sin_out;
  logic signed [OUT_W-1:0] cos_out;
  logic ovf_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  quad_osc #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) i_quad_osc (
    .clk(clk), .rst_n(rst_n), .load(load), .amp_init(amp_init),
    .sin_out(sin_out), .cos_out(cos_out), .ovf_flag(ovf_flag)
  );

  typedef struct {
    longint s;
    longint c;
    bit     o;
    string  tag;
  } exp_t;
  exp_t sb[$];

  longint ms = 0, mc = 0;
  bit movf = 1'b0;

  // Floor division written with quotient and remainder.
  function automatic longint fdiv(longint x, longint d);
    longint q;
    q = x / d;
    if ((x % d) != 0 && x < 0) q = q - 1;
    return q;
  endfunction

  function automatic longint limit(longint x, ref bit hit);
    if (x > TOPV) begin hit = 1'b1; return TOPV; end
    if (x < BOTV) begin hit = 1'b1; return BOTV; end
    return x;
  endfunction

  task automatic check(string tag, longint act, longint expv, string what);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected state.
  task automatic step(bit ld, longint amp, string tag);
    longint ns, nc;
    bit hit;
    exp_t e;
    @(negedge clk);
    rst_n = 1'b1;
    load = ld;
    amp_init = ACC_W'(amp);
    hit = 1'b0;
    if (ld) begin
      ms = 0; mc = amp; movf = 1'b0;
    end else begin
      ns = limit(ms + fdiv(mc, FSTEP), hit);
      nc = limit(mc - fdiv(ms, FSTEP), hit);
      ms = ns; mc = nc;
      if (hit) movf = 1'b1;
    end
    e.s = ms; e.c = mc; e.o = movf; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic apply_reset(string tag);
    exp_t e;
    @(negedge clk);
    rst_n = 1'b0;
    load = 1'b0;
    ms = 0; mc = 0; movf = 1'b0;
    e.s = 0; e.c = 0; e.o = 1'b0; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares each cycle after the edge has settled.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, longint'(sin_out), fdiv(e.s, FOUT), "sin_out");
        check(e.tag, longint'(cos_out), fdiv(e.c, FOUT), "cos_out");
        check(e.tag, longint'(ovf_flag), longint'(e.o), "ovf_flag");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    // R1: reset state before any clock edge
    check("R1", longint'(sin_out), 0, "sin_out");
    check("R1", longint'(cos_out), 0, "cos_out");
    check("R1", longint'(ovf_flag), 0, "ovf_flag");

    // R2: no preload, the zero state must stay at zero
    for (int i = 0; i < 20; i++) step(1'b0, 0, "R2");

    // R3 then R4 R5 R6 with a positive amplitude
    step(1'b1, 64'sh100000, "R3");
    for (int i = 0; i < 600; i++) step(1'b0, 0, "R4 R5 R6");

    // R1 reset in mid run
    apply_reset("R1");
    step(1'b0, 0, "R2");

    // Negative amplitude with nonzero low bits: floor behaviour
    step(1'b1, -64'sh2EDCBA, "R3");
    for (int i = 0; i < 500; i++) step(1'b0, 0, "R4 R5 R6");

    // Full-scale amplitude: clamping and sticky flag
    step(1'b1, TOPV, "R3");
    for (int i = 0; i < 900; i++) step(1'b0, 0, "R7 R8");

    // Full-scale negative amplitude
    step(1'b1, BOTV, "R3");
    for (int i = 0; i < 700; i++) step(1'b0, 0, "R7 R8");

    // Load clears the flag
    step(1'b1, 64'sh012345, "R3 R8");
    for (int i = 0; i < 10; i++) step(1'b0, 0, "R4 R6");

    apply_reset("R1");
    step(1'b0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    // R8: the model must have exercised a clamp in the full-scale runs
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule